// File: doc/BRIEF.md
# Masked-Page Translation Lookaside Buffer

This block is a fully associative translation cache. Each slot holds a virtual page number, a per-slot page mask, an address-space identifier, a global flag, two valid flags and two physical frame numbers. A lookup presents a virtual address, the current address-space identifier and a flag marking an instruction fetch. One cycle later the block returns whether a slot matched, the index of that slot and its full contents. It also returns two side flags: whether the access must bypass the cache with strict ordering, and whether the fetch address was misaligned.

Software maintains the slots through three controls:
- an indexed write port,
- a flush that wipes every slot,
- a round-robin victim pointer. The caller can read the slot under this pointer and advance the pointer to choose where the next refill goes.

Page-table walking and refill are left to the caller.

Slot contents are carried as one flat vector. Its fields, from most to least significant bit, are: vpn [90:71], mask [70:51], asid [50:43], global [42], valid0 [41], valid1 [40], frame0 [39:20], frame1 [19:0]. The virtual page number of an address is bits [31:12].

Top module: `xlat_tlb`

## Requirements
- R1: A slot's page number matches when it equals the lookup page number in every bit that is clear in that slot's mask. Bits set in the mask are not compared.
- R2: A slot matches only if its global bit [42] is 1 or its stored asid equals the lookup asid.
- R3: When several slots match, the lowest index is reported. On a miss, rsp_hit is 0, rsp_idx is 0 and rsp_entry is all zero.
- R4: A slot takes part in matching when valid0 [41] or valid1 [40] is 1. A slot with both valid flags at 0 never matches.
- R5: An indexed write replaces the whole slot at wr_idx from the next cycle on. A lookup in the same cycle as the write sees the old contents.
- R6: A flush zeroes every slot and sets vic_ptr to 0. A write or advance in the same cycle is overridden.
- R7: A victim read returns, one cycle later on vic_entry with vic_valid high, the slot at the pointer value before the edge. An advance moves the pointer by one and wraps from NUM_ENTRIES-1 to 0.
- R8: A write with wr_idx >= NUM_ENTRIES changes no slot and makes wr_err high for exactly the following cycle.
- R9: A lookup with lk_ifetch high and either of address bits [1:0] nonzero reports rsp_fault=1 and rsp_hit=0.
- R10: rsp_uncached is 1 exactly when address bits 31 and 29 are both 1. This is reported whether or not the lookup hits.
- R11: rsp_valid is high in the cycle after lk_req. When there was no request, rsp_valid, rsp_hit, rsp_fault and rsp_uncached are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| wr_en | input | 1 | Indexed slot write |
| wr_idx | input | 4 | Slot index to write |
| wr_entry | input | 91 | Slot contents to write |
| flush | input | 1 | Clear all slots and the victim pointer |
| vic_rd | input | 1 | Read the slot under the victim pointer |
| vic_adv | input | 1 | Advance the victim pointer |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A slot matched |
| rsp_idx | output | 3 | Index of the matching slot |
| rsp_entry | output | 91 | Contents of the matching slot |
| rsp_uncached | output | 1 | Access must be uncached and strictly ordered |
| rsp_fault | output | 1 | Misaligned instruction fetch |
| wr_err | output | 1 | Out-of-range write rejected |
| vic_ptr | output | 3 | Current victim pointer |
| vic_valid | output | 1 | Victim read result valid |
| vic_entry | output | 91 | Slot read at the victim pointer |

## Verification
Random slots are drawn from a small pool of page numbers with random narrow masks, four identifiers and a mix of global and valid flags. Lookups then land on exact matches, on matches that differ only in masked bits, and on clear misses. This separates a wrong mask polarity from a wrong identifier check. Because pool entries repeat, several slots often match at once, which exposes any priority error. Directed cases cover the corners:
- slots valid through only one of the two flags;
- a write and a lookup in the same cycle;
- a flush racing a write;
- an out-of-range index;
- the pointer wrap;
- misaligned fetches against aligned data accesses at the same address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VPN_W  = 20;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 20;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              v0;
    logic              v1;
    logic [PFN_W-1:0]  pfn0;
    logic [PFN_W-1:0]  pfn1;
  } tlb_ent_t;

  localparam int ENT_W = $bits(tlb_ent_t);
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 6
) (
  input  tlb_ent_t          slots [NUM_ENTRIES],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic [NUM_ENTRIES-1:0] match_vec
);
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    logic live, tag_ok, id_ok;
    always_comb begin
      live   = slots[e].v0 | slots[e].v1;
      tag_ok = ((vpn ^ slots[e].vpn) & ~slots[e].mask) == '0;
      id_ok  = slots[e].glob | (slots[e].asid == asid);
      match_vec[e] = live & tag_ok & id_ok;
    end
  end
endmodule

// File: rtl/xlat_first_set.sv
module xlat_first_set #(
  parameter int WIDTH = 6,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_victim_ctr.sv
module xlat_victim_ctr #(
  parameter int NUM_ENTRIES = 6,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || flush)  ptr <= '0;
    else if (adv)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!flush && adv && ptr != LAST) |=> ptr == $past(ptr) + 1'b1); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!flush && adv && ptr == LAST) |=> ptr == '0); // R7
  AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (rst)
    flush |=> ptr == '0); // R6
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int          NUM_ENTRIES = 6,
  parameter int          PAGE_SHIFT  = 12,
  parameter logic [31:0] UNC_MASK    = 32'hA000_0000,
  localparam int VA_W = VPN_W + PAGE_SHIFT,
  localparam int IW   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WIW  = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ifetch,
  input  logic              wr_en,
  input  logic [WIW-1:0]    wr_idx,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic              flush,
  input  logic              vic_rd,
  input  logic              vic_adv,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IW-1:0]     rsp_idx,
  output logic [ENT_W-1:0]  rsp_entry,
  output logic              rsp_uncached,
  output logic              rsp_fault,
  output logic              wr_err,
  output logic [IW-1:0]     vic_ptr,
  output logic              vic_valid,
  output logic [ENT_W-1:0]  vic_entry
);
  tlb_ent_t slots [NUM_ENTRIES];
  tlb_ent_t wr_ent;
  assign wr_ent = tlb_ent_t'(wr_entry);

  // slot storage, one register bank per slot
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush)
        slots[e] <= '0;
      else if (wr_en && wr_idx == WIW'(e))
        slots[e] <= wr_ent;
    end
  end

  // combinational lookup path
  logic [VPN_W-1:0]       lk_vpn;
  logic [NUM_ENTRIES-1:0] match_vec;
  logic                   any_match;
  logic [IW-1:0]          first_idx;
  logic                   misalign, uncached, hit_c;

  assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_SHIFT];
  assign misalign = lk_ifetch & (|lk_vaddr[1:0]);
  assign uncached = (lk_vaddr & VA_W'(UNC_MASK)) == VA_W'(UNC_MASK);
  assign hit_c    = any_match & ~misalign;

  xlat_tag_cmp #(.NUM_ENTRIES(NUM_ENTRIES)) u_cmp (
    .slots     (slots),
    .vpn       (lk_vpn),
    .asid      (lk_asid),
    .match_vec (match_vec)
  );

  xlat_first_set #(.WIDTH(NUM_ENTRIES)) u_pick (
    .vec (match_vec),
    .any (any_match),
    .idx (first_idx)
  );

  xlat_victim_ctr #(.NUM_ENTRIES(NUM_ENTRIES)) u_vic (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .adv   (vic_adv),
    .ptr   (vic_ptr)
  );

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_idx      <= '0;
      rsp_entry    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= 1'b0;
    end else begin
      rsp_valid    <= lk_req;
      rsp_hit      <= lk_req & hit_c;
      rsp_uncached <= lk_req & uncached;
      rsp_fault    <= lk_req & misalign;
      if (lk_req) begin
        rsp_idx   <= hit_c ? first_idx : '0;
        rsp_entry <= hit_c ? ENT_W'(slots[first_idx]) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && (wr_idx >= WIW'(NUM_ENTRIES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_valid <= 1'b0;
      vic_entry <= '0;
    end else begin
      vic_valid <= vic_rd;
      if (vic_rd) vic_entry <= ENT_W'(slots[vic_ptr]);
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid); // R11
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit && !rsp_fault); // R11
  AST_FAULT_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> !rsp_hit); // R9
  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_idx < IW'(NUM_ENTRIES)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_entry == '0)); // R3
  AST_WR_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= WIW'(NUM_ENTRIES)) |=> wr_err); // R8
  AST_HIT_LIVE: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_entry[41] | rsp_entry[40])); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (flush && !lk_req) |=> (lk_req |=> !rsp_hit)); // R6
endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
  import xlat_pkg::*;
  localparam int N = 6;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic lk_req = 0, lk_ifetch = 0, wr_en = 0, flush = 0, vic_rd = 0, vic_adv = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [3:0]  wr_idx = '0;
  logic [ENT_W-1:0] wr_entry = '0;
  logic rsp_valid, rsp_hit, rsp_uncached, rsp_fault, wr_err, vic_valid;
  logic [2:0] rsp_idx, vic_ptr;
  logic [ENT_W-1:0] rsp_entry, vic_entry;

  xlat_tlb #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_ifetch(lk_ifetch), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .flush(flush), .vic_rd(vic_rd), .vic_adv(vic_adv), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_entry(rsp_entry),
    .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault), .wr_err(wr_err),
    .vic_ptr(vic_ptr), .vic_valid(vic_valid), .vic_entry(vic_entry)
  );

  int checks = 0, errors = 0;
  tlb_ent_t mdl [N];
  int mptr = 0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic tlb_ent_t mk(logic [19:0] vpn, logic [19:0] msk, logic [7:0] asid,
                                  logic g, logic v0, logic v1, logic [19:0] f0, logic [19:0] f1);
    tlb_ent_t t;
    t.vpn = vpn; t.mask = msk; t.asid = asid; t.glob = g;
    t.v0 = v0; t.v1 = v1; t.pfn0 = f0; t.pfn1 = f1;
    return t;
  endfunction

  function automatic bit ref_match(tlb_ent_t t, logic [19:0] vpn, logic [7:0] asid);
    return (t.v0 || t.v1) && (((vpn ^ t.vpn) & ~t.mask) == 0) && (t.glob || t.asid == asid);
  endfunction

  // One cycle: drive, compute expectations from the model, clock, compare.
  task automatic step(string tag, logic req, logic [31:0] va, logic [7:0] asid, logic ifetch,
                      logic wen, logic [3:0] widx, tlb_ent_t went,
                      logic fl, logic vrd, logic vadv);
    logic e_hit, e_mis, e_unc, e_err;
    logic [2:0] e_idx;
    tlb_ent_t e_ent, e_vic;
    lk_req = req; lk_vaddr = va; lk_asid = asid; lk_ifetch = ifetch;
    wr_en = wen; wr_idx = widx; wr_entry = went; flush = fl; vic_rd = vrd; vic_adv = vadv;
    e_mis = ifetch && (va[1:0] != 0);
    e_unc = va[31] && va[29];
    e_hit = 0; e_idx = 0; e_ent = '0;
    for (int i = N - 1; i >= 0; i--)
      if (ref_match(mdl[i], va[31:12], asid)) begin e_hit = 1; e_idx = 3'(i); e_ent = mdl[i]; end
    if (e_mis) begin e_hit = 0; e_idx = 0; e_ent = '0; end
    if (!e_hit) begin e_idx = 0; e_ent = '0; end
    e_err = wen && (widx >= N);
    e_vic = mdl[mptr];
    if (fl) begin
      for (int i = 0; i < N; i++) mdl[i] = '0;
      mptr = 0;
    end else begin
      if (wen && widx < N) mdl[widx] = went;
      if (vadv) mptr = (mptr == N - 1) ? 0 : mptr + 1;
    end
    @(posedge clk); #1;
    chk({tag, " R11 rsp_valid"}, 128'(rsp_valid), 128'(req));
    chk({tag, " R3 rsp_hit"}, 128'(rsp_hit), 128'(req & e_hit));
    chk({tag, " R9 rsp_fault"}, 128'(rsp_fault), 128'(req & e_mis));
    chk({tag, " R10 rsp_uncached"}, 128'(rsp_uncached), 128'(req & e_unc));
    if (req) begin
      chk({tag, " R3 rsp_idx"}, 128'(rsp_idx), 128'(e_idx));
      chk({tag, " R1 rsp_entry"}, 128'(rsp_entry), 128'(e_ent));
    end
    chk({tag, " R8 wr_err"}, 128'(wr_err), 128'(e_err));
    chk({tag, " R7 vic_ptr"}, 128'(vic_ptr), 128'(mptr));
    chk({tag, " R7 vic_valid"}, 128'(vic_valid), 128'(vrd));
    if (vrd) chk({tag, " R7 vic_entry"}, 128'(vic_entry), 128'(e_vic));
  endtask

  task automatic look(string tag, logic [31:0] va, logic [7:0] asid, logic ifetch);
    step(tag, 1, va, asid, ifetch, 0, 0, '0, 0, 0, 0);
  endtask

  task automatic wr(string tag, int idx, tlb_ent_t t);
    step(tag, 0, 0, 0, 0, 1, 4'(idx), t, 0, 0, 0);
  endtask

  function automatic logic [19:0] pool_vpn(int k);
    case (k % 5)
      0: return 20'h12340;
      1: return 20'h12341;
      2: return 20'hA5500;
      3: return 20'hE0F0F;
      default: return 20'h0ABCD;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    // reset state
    chk("R6 reset vic_ptr", 128'(vic_ptr), 0);
    chk("R11 reset rsp_valid", 128'(rsp_valid), 0);
    look("R4 empty miss", 32'h1234_0000, 8'd1, 0);

    // R1 masked compare
    wr("R5 write0", 0, mk(20'h12340, 20'h0000F, 8'd1, 0, 1, 0, 20'h11111, 20'h22222));
    look("R1 masked bits differ", 32'h1234_7004, 8'd1, 0);
    look("R1 unmasked bit differs", 32'h1235_0004, 8'd1, 0);
    // R2 asid and global
    look("R2 asid mismatch", 32'h1234_0000, 8'd2, 0);
    wr("R5 write3 global", 3, mk(20'h12340, 20'h0, 8'd9, 1, 0, 1, 20'h33333, 20'h44444));
    look("R2 global hit", 32'h1234_0000, 8'd2, 0);
    look("R3 lowest wins", 32'h1234_0000, 8'd1, 0);
    // R4 both valids clear
    wr("R4 write1 dead", 1, mk(20'h55555, 20'h0, 8'd1, 1, 0, 0, 20'h1, 20'h2));
    look("R4 dead slot", 32'h5555_5000, 8'd1, 0);
    // R5 write and lookup same cycle
    step("R5 same-cycle", 1, 32'h5555_5000, 8'd1, 0, 1, 4'd1,
         mk(20'h55555, 20'h0, 8'd1, 1, 1, 1, 20'h7, 20'h8), 0, 0, 0);
    look("R5 after write", 32'h5555_5000, 8'd1, 0);
    // R8 out of range
    step("R8 oob", 0, 0, 0, 0, 1, 4'd6, mk(20'h66666, 0, 0, 1, 1, 1, 0, 0), 0, 0, 0);
    look("R8 oob no effect", 32'h6666_6000, 8'd0, 0);
    step("R8 oob max", 0, 0, 0, 0, 1, 4'd15, mk(20'h66666, 0, 0, 1, 1, 1, 0, 0), 0, 0, 0);
    // R9 misaligned fetch vs data
    look("R9 fetch misaligned", 32'h1234_0002, 8'd1, 1);
    look("R9 data same addr", 32'h1234_0002, 8'd1, 0);
    look("R9 fetch aligned", 32'h1234_0004, 8'd1, 1);
    // R10 uncached pattern
    look("R10 A0 pattern", 32'hA000_0000, 8'd1, 0);
    look("R10 partial", 32'h8000_0000, 8'd1, 0);
    look("R10 all set", 32'hF234_0000, 8'd1, 0);
    // R7 victim read, advance, wrap
    for (int i = 0; i < N + 2; i++)
      step("R7 walk", 0, 0, 0, 0, 0, 0, '0, 0, 1, 1);
    // R6 flush beats write and advance
    step("R6 flush+write", 0, 0, 0, 0, 1, 4'd2,
         mk(20'h12340, 0, 1, 1, 1, 1, 5, 5), 1, 0, 1);
    look("R6 after flush", 32'h1234_0000, 8'd1, 0);
    step("R6 vic after flush", 0, 0, 0, 0, 0, 0, '0, 0, 1, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      tlb_ent_t t;
      logic [19:0] msk;
      case (r[1:0]) 0: msk = 0; 1: msk = 20'h1; 2: msk = 20'h3; default: msk = 20'hF; endcase
      t = mk(pool_vpn(int'(r[4:2])), msk, 8'(r[6:5]), r[8:7] == 0, r[9], r[10],
             20'($urandom), 20'($urandom));
      step("rnd", r[11] | r[12], {pool_vpn(int'(r[15:13])) ^ 20'(r[17:16]), 12'($urandom)},
           8'(r[19:18]), r[20], r[21] & r[22], 4'($urandom % 8), t,
           r[31:26] == 0, r[23], r[24] & r[25]);
    end
    step("idle", 0, 0, 0, 0, 0, 0, '0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule